// File: doc/BRIEF.md
# Configuration Request Engine

This block sits inside a PCIe root port and turns a header composed by software into one configuration request on the wire. Software writes the three header words and, for a write access, a data word into memory-mapped registers, then sets a start bit. The engine streams the header words, followed by the data word when the header says the request carries data, toward the link layer on a valid/ready stream. It marks the final word with a last flag.

After the last word is accepted, the engine waits for a completion on an inbound stream. When the completion arrives, it stores the completion status and, for a read, the 32-bit payload. It then drops the busy bit. If no completion comes within a set number of cycles, the engine writes a timeout status code instead. Software polls the busy bit and checks the status field before it uses the read data.

The engine does not pack or check the header fields. Software builds them, and they go out unchanged. Byte-lane shifting of write data is also left to software.

Top module: `cfg_req_engine`

## Requirements
- R1: After reset, the request/status register (offset 0x488) reads 0, the read-data register (offset 0x48C) reads 0, and `tlp_valid` is low.
- R2: While idle, a write to offset 0x460, 0x464 or 0x468 (header words 0..2) or to 0x470 (write data) stores the value, and a read of the same offset returns it.
- R3: While idle, writing the request register with bit 0 set starts a request. Bit 0 (busy) then reads 1, and the status field in bits 7:5 reads 0.
- R4: A started request sends header words 0, 1, 2 in that order. If bit 30 of header word 0 is set (format code 2 in bits 31:29, a write), the write-data word follows as a fourth word. `tlp_last` is high only on the final word. While `tlp_ready` is low, the offered word and flag hold.
- R5: A completion accepted while waiting clears busy and copies `cpl_status` into bits 7:5 of the request register. A nonzero value marks a failed access.
- R6: The completion of a request without data (a read) places `cpl_data` in the read-data register. The completion of a write leaves that register unchanged.
- R7: If no completion arrives within TIMEOUT_CYC cycles after the last word is accepted, busy clears and bits 7:5 take TIMEOUT_CODE (default 3'b111).
- R8: While busy, writes to the header, data and request registers are ignored. The stored values and the words sent do not change.
- R9: A completion that arrives while the engine is idle is ignored. Status and read data keep their values.
- R10: Header fields pass through unchanged on the stream:
  - word 0 carries the length 1 in bits 9:0, the type 4 in bits 28:24 and the format in bits 31:29;
  - word 1 carries the byte-enable mask;
  - word 2 carries the register number in bits 11:2, the function in bits 18:16, the device in bits 23:19 and the bus in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tlp_valid | output | 1 | Outbound word valid |
| tlp_ready | input | 1 | Link layer accepts the word |
| tlp_data | output | 32 | Outbound word |
| tlp_last | output | 1 | Final word of the request |
| cpl_valid | input | 1 | Completion present (single cycle) |
| cpl_status | input | 3 | Completion status, 0 means success |
| cpl_data | input | 32 | Completion payload |

## Verification
The hardest states to reach from the ports are the narrow windows around a transaction. These are a register write that lands while the request is still streaming or waiting, a completion that never comes, and a stray completion that shows up after the engine has gone idle. The bench reaches them from its own stimulus. It turns the completion responder off for the timeout case. It issues header and start writes right after a start, while the engine is still busy. Once idle, it drives a completion pulse by hand. A backpressure pattern on `tlp_ready` holds words mid-stream so that the stall behaviour is exercised.

// File: rtl/cfg_req_engine.sv
module cfg_req_engine #(
  parameter int AW           = 12,
  parameter int TIMEOUT_CYC  = 4096,
  parameter logic [2:0] TIMEOUT_CODE = 3'b111,
  parameter logic [AW-1:0] OFF_HDR0  = 'h460,
  parameter logic [AW-1:0] OFF_HDR1  = 'h464,
  parameter logic [AW-1:0] OFF_HDR2  = 'h468,
  parameter logic [AW-1:0] OFF_WDATA = 'h470,
  parameter logic [AW-1:0] OFF_REQ   = 'h488,
  parameter logic [AW-1:0] OFF_RDATA = 'h48C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tlp_valid,
  input  logic          tlp_ready,
  output logic [31:0]   tlp_data,
  output logic          tlp_last,
  input  logic          cpl_valid,
  input  logic [2:0]    cpl_status,
  input  logic [31:0]   cpl_data
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int DATA_BIT = 30;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;

  state_t        state_q;
  logic [1:0]    idx_q;
  logic [TW-1:0] wait_q;
  logic          has_data_q;
  logic [31:0]   hdr0_q, hdr1_q, hdr2_q, wdata_q, rdata_q;
  logic [2:0]    status_q;
  logic          busy, wr_ok, start;

  assign busy  = state_q != S_IDLE;
  assign wr_ok = reg_wr && !busy;
  assign start = wr_ok && reg_addr == OFF_REQ && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      wait_q     <= '0;
      has_data_q <= 1'b0;
      hdr0_q     <= '0;
      hdr1_q     <= '0;
      hdr2_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      status_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (wr_ok) begin
            if (reg_addr == OFF_HDR0)  hdr0_q  <= reg_wdata;
            if (reg_addr == OFF_HDR1)  hdr1_q  <= reg_wdata;
            if (reg_addr == OFF_HDR2)  hdr2_q  <= reg_wdata;
            if (reg_addr == OFF_WDATA) wdata_q <= reg_wdata;
          end
          if (start) begin
            state_q    <= S_SEND;
            idx_q      <= '0;
            status_q   <= '0;
            has_data_q <= hdr0_q[DATA_BIT];
          end
        end
        S_SEND: begin
          if (tlp_ready) begin
            if (tlp_last) begin
              state_q <= S_WAIT;
              wait_q  <= '0;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
        end
        S_WAIT: begin
          if (cpl_valid) begin
            status_q <= cpl_status;
            if (!has_data_q) rdata_q <= cpl_data;
            state_q  <= S_IDLE;
          end else if (wait_q == TW'(TIMEOUT_CYC - 1)) begin
            status_q <= TIMEOUT_CODE;
            state_q  <= S_IDLE;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tlp_valid = state_q == S_SEND;
  assign tlp_last  = tlp_valid && (idx_q == (has_data_q ? 2'd3 : 2'd2));

  always_comb begin
    case (idx_q)
      2'd0:    tlp_data = hdr0_q;
      2'd1:    tlp_data = hdr1_q;
      2'd2:    tlp_data = hdr2_q;
      default: tlp_data = wdata_q;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_HDR0)  reg_rdata = hdr0_q;
    if (reg_addr == OFF_HDR1)  reg_rdata = hdr1_q;
    if (reg_addr == OFF_HDR2)  reg_rdata = hdr2_q;
    if (reg_addr == OFF_WDATA) reg_rdata = wdata_q;
    if (reg_addr == OFF_REQ)   reg_rdata = {24'd0, status_q, 4'd0, busy};
    if (reg_addr == OFF_RDATA) reg_rdata = rdata_q;
  end
endmodule

// File: rtl/cfg_req_engine_chk.sv
module cfg_req_engine_chk #(
  parameter int TW = 8,
  parameter int TIMEOUT_CYC = 100,
  parameter logic [2:0] TIMEOUT_CODE = 3'b111
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start,
  input logic          tlp_valid,
  input logic          tlp_ready,
  input logic [31:0]   tlp_data,
  input logic          tlp_last,
  input logic          cpl_valid,
  input logic [2:0]    cpl_status,
  input logic [2:0]    status_q,
  input logic [31:0]   rdata_q,
  input logic [TW-1:0] wait_q
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlp_valid && !tlp_ready |=> tlp_valid && $stable(tlp_data) && $stable(tlp_last));

  // R4
  send_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlp_valid |-> busy);

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && status_q == 3'd0);

  // R5
  cpl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tlp_valid && cpl_valid |=> !busy && status_q == $past(cpl_status));

  // R7
  timeout_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(cpl_valid) |-> status_q == TIMEOUT_CODE);

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q < TW'(TIMEOUT_CYC));

  // R9
  idle_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cpl_valid && !start |=> $stable(rdata_q) && $stable(status_q));
endmodule

bind cfg_req_engine cfg_req_engine_chk #(
  .TW(TW), .TIMEOUT_CYC(TIMEOUT_CYC), .TIMEOUT_CODE(TIMEOUT_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start),
  .tlp_valid(tlp_valid), .tlp_ready(tlp_ready), .tlp_data(tlp_data),
  .tlp_last(tlp_last), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
  .status_q(status_q), .rdata_q(rdata_q), .wait_q(wait_q)
);

// File: tb/cfg_req_engine_tb_top.sv
module cfg_req_engine_tb_top;
  localparam int TO = 40;

  logic clk = 0, rst_n = 0;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tlp_valid, tlp_ready = 1, tlp_last;
  logic [31:0] tlp_data;
  logic cpl_valid = 0;
  logic [2:0] cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int checks = 0, failures = 0;
  bit finished = 0, resp_en = 1, bp_en = 0;
  logic [2:0] resp_status = '0;
  logic [31:0] resp_data = '0;
  logic [32:0] exp_q[$];
  int cyc = 0;

  always #2 clk = ~clk;

  cfg_req_engine #(.TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tlp_valid(tlp_valid),
    .tlp_ready(tlp_ready), .tlp_data(tlp_data), .tlp_last(tlp_last),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_h0(bit wr);
    return {(wr ? 3'd2 : 3'd0), 5'd4, 14'd0, 10'd1};
  endfunction

  function automatic logic [31:0] mk_h2(int bus, int dev, int fn, int regn);
    return {bus[7:0], dev[4:0], fn[2:0], 4'd0, regn[11:2], 2'b00};
  endfunction

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic launch(logic [31:0] h0, h1, h2, wd);
    reg_write(12'h460, h0);
    reg_write(12'h464, h1);
    reg_write(12'h468, h2);
    reg_write(12'h470, wd);
    exp_q.push_back({1'b0, h0});
    exp_q.push_back({1'b0, h1});
    if (h0[30]) begin
      exp_q.push_back({1'b0, h2});
      exp_q.push_back({1'b1, wd});
    end else begin
      exp_q.push_back({1'b1, h2});
    end
    reg_write(12'h488, 32'h1);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      reg_read(12'h488, v);
      if (!v[0]) return;
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && tlp_valid && tlp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4/R8 unexpected word actual=%h expected=none", tlp_data);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk("R4/R10 stream word", {31'd0, tlp_last} << 0 | 32'(tlp_last), 32'(e[32]));
        chk("R4/R10 stream data", tlp_data, e[31:0]);
      end
    end
  end

  // completion responder
  initial forever begin
    @(negedge clk);
    if (rst_n && tlp_valid && tlp_ready && tlp_last && resp_en) begin
      repeat (5) @(posedge clk);
      #1;
      cpl_valid = 1; cpl_status = resp_status; cpl_data = resp_data;
      @(posedge clk); #1;
      cpl_valid = 0;
    end
  end

  // backpressure pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tlp_ready = !bp_en || (cyc[0] ^ cyc[2]);
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, h0w, h2w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    reg_read(12'h488, v); chk("R1 req reg", v, 32'h0);
    reg_read(12'h48C, v); chk("R1 rdata", v, 32'h0);
    chk("R1 tlp_valid", 32'(tlp_valid), 32'h0);

    // R2 register readback
    reg_write(12'h464, 32'hA5A5_0F0F);
    reg_read(12'h464, v); chk("R2 hdr1 readback", v, 32'hA5A5_0F0F);

    // R4 R10 write request: size 2 at offset 2 -> BE 4'b1100
    h0w = mk_h0(1);
    h2w = mk_h2(3, 5, 2, 'h12);
    launch(h0w, 32'h0000_000C, h2w, 32'hBEEF_0000);
    reg_read(12'h488, v); chk("R3 busy and status cleared", v, 32'h1);
    wait_idle();
    reg_read(12'h488, v); chk("R5 write done ok", v, 32'h0);
    reg_read(12'h48C, v); chk("R6 write leaves rdata", v, 32'h0);

    // R6 read with backpressure
    bp_en = 1; resp_data = 32'h1234_5678;
    launch(mk_h0(0), 32'h0000_000F, mk_h2(1, 0, 0, 'h8), 32'h0);
    wait_idle();
    bp_en = 0;
    reg_read(12'h48C, v); chk("R6 read payload", v, 32'h1234_5678);
    reg_read(12'h488, v); chk("R5 read status ok", v, 32'h0);

    // R5 failing status
    resp_status = 3'b001; resp_data = 32'hCAFE_0001;
    launch(mk_h0(0), 32'h1, mk_h2(0, 1, 0, 'h0), 32'h0);
    // R8 writes while busy are ignored
    reg_write(12'h460, 32'hFFFF_FFFF);
    reg_write(12'h488, 32'h1);
    wait_idle();
    reg_read(12'h488, v); chk("R5 failed status", v, 32'h20);
    reg_read(12'h460, v); chk("R8 hdr0 kept", v, mk_h0(0));

    // R3 new start clears old status
    resp_status = 3'b000; resp_data = 32'h0BAD_F00D;
    launch(mk_h0(0), 32'h3, mk_h2(2, 3, 1, 'h40), 32'h0);
    reg_read(12'h488, v); chk("R3 status cleared on start", v, 32'h1);
    wait_idle();
    reg_read(12'h48C, v); chk("R6 second read payload", v, 32'h0BAD_F00D);

    // R7 timeout
    resp_en = 0;
    launch(mk_h0(0), 32'h1, mk_h2(0, 2, 0, 'h4), 32'h0);
    repeat (TO / 2) @(posedge clk);
    reg_read(12'h488, v); chk("R7 still waiting", v, 32'h1);
    wait_idle();
    reg_read(12'h488, v); chk("R7 timeout code", v, 32'hE0);
    reg_read(12'h48C, v); chk("R7 rdata kept", v, 32'h0BAD_F00D);

    // R9 stray completion while idle
    @(posedge clk); #1;
    cpl_valid = 1; cpl_status = 3'b010; cpl_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    cpl_valid = 0;
    reg_read(12'h48C, v); chk("R9 rdata ignored", v, 32'h0BAD_F00D);
    reg_read(12'h488, v); chk("R9 status ignored", v, 32'hE0);
    resp_en = 1;

    repeat (5) @(posedge clk);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule